// File: doc/BRIEF.md
# TDM Telecom Serial Frame Port

This block is a time-division-multiplexed serial port for telecom links. It runs entirely on the external serial clock and locks onto an external frame-sync input. It turns one receive line into a stream of 8-bit timeslot bytes. It turns a stream of timeslot bytes into one transmit line. The transmit line has a per-timeslot output enable, and the pad uses that enable to drive the line or leave it at high impedance.

A two-bit rate code selects the frame length: 128, 256 or 512 slots. A mode input selects one clock per bit, or two clocks per bit with the serial clock running at twice the bit rate. A polarity input flips the sense of frame sync. A second input moves receive capture to the falling edge. A data-delay count places the first bit of slot 0 a chosen number of bit periods after the sync-sampling edge. That count wraps modulo the frame length in bits, so a large delay can place slot 0 before the sync.

Receive bytes leave as a one-cycle valid pulse carrying the slot index. The serial line cannot stall, so this stream has no back-pressure and the consumer must take every pulse. Transmit bytes are requested one slot ahead. The port raises `tx_req` with the slot index, then accepts one byte through `tx_push`/`tx_ready`. A byte is taken on a clock where both are high. Once a byte is held, `tx_ready` stays low until the held byte is consumed at the start of the next slot.

Top module: `tdm_serial_port`

## Requirements
- R1: `rate` 0, 1 and 2 give frames of 128, 256 and 512 slots; code 3 behaves as 2. Every slot has 8 bits, carried most significant first. Position p in the frame is bit (7 - p mod 8) of slot p/8.
- R2: A frame sync is a rising edge of `fsync ^ fs_inv`, sampled on a rising clock. The bit period that begins at that edge gets position (N - delay) mod N, where N is the frame length in bits. So slot 0 bit 7 begins `delay` bit periods after the sync.
- R3: With `mode2x`=0 each bit lasts one clock. With `mode2x`=1 each bit lasts two clocks, and receive data is taken at the rising edge in the middle of the bit.
- R4: With `rx_fall`=1 the receive bit is the value `rx_in` held at the falling edge before the capture edge. With `rx_fall`=0 it is the value at the capture edge itself.
- R5: After the last bit of a slot, `rx_valid` pulses high for one cycle with `rx_byte` and `rx_slot`. A slot whose bit 7 was not captured since the last realignment produces no byte.
- R6: `tx_dat` and `tx_en` change only on falling edges, and only at the start of a bit. `tx_en` equals bit s of `tx_mask` for slot s. When enabled, `tx_dat` carries the slot byte most significant bit first.
- R7: At the first clock of slot s, `tx_req` pulses for one cycle with `tx_req_slot` = (s+1) mod slots. The byte accepted after that pulse is sent in slot s+1. If no byte was accepted, that slot sends 8'hFF.
- R8: A frame sync arriving exactly at the expected frame boundary has no effect. Any other sync raises `resync` for one cycle and realigns the frame.
- R9: From reset until the first frame sync, `tx_en`, `rx_valid`, `tx_req` and `resync` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate | input | 2 | Frame length code |
| mode2x | input | 1 | Two clocks per bit when set |
| fs_inv | input | 1 | Frame sync is active low when set |
| rx_fall | input | 1 | Capture receive data on the falling edge |
| delay | input | 12 | Data delay in bit periods, taken modulo frame length |
| fsync | input | 1 | Frame sync |
| rx_in | input | 1 | Serial receive data |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| rx_slot | output | 9 | Slot index of the received byte |
| tx_mask | input | 512 | Per-slot transmit enable |
| tx_req | output | 1 | Next-slot byte request strobe |
| tx_req_slot | output | 9 | Slot index being requested |
| tx_push | input | 1 | Transmit byte valid |
| tx_byte | input | 8 | Transmit byte |
| tx_ready | output | 1 | Port can accept a transmit byte |
| tx_dat | output | 1 | Serial transmit data |
| tx_en | output | 1 | Transmit drive enable, low means high impedance |
| resync | output | 1 | Misaligned frame sync seen |

## Verification
The bench targets data delays that do not fall on a slot boundary. There, a design that lets a partial first slot through emits a corrupt byte, and the slot sequence check catches it. It also runs a delay that wraps past the frame end. A design that does not wrap would place slot 0 a frame late and mislabel every byte. It checks two-clock mode with inverted sync. A design that captures on the wrong half of the bit, or treats inverted sync as its own edge, misreads every bit. Falling-edge capture is checked by corrupting the line after the falling edge, and the corruption is visible only to rising-edge capture. Finally, the bench delivers frame syncs both on and off the frame boundary and counts `resync` pulses. A design that realigns on every sync would misplace bytes at the boundary, and one that ignores misaligned syncs would never pulse.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Frame length in bits for a rate code; codes above 2 saturate at x4.
  function automatic int unsigned frame_bits(input logic [1:0] rate, input int unsigned base);
    return base << ((rate > 2'd2) ? 2 : int'(rate));
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int POS_W     = 12,
  parameter int BIDX_W    = 3,
  parameter int BASE_BITS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_raw,
  input  logic             fs_inv,
  input  logic             mode2x,
  input  logic [1:0]       rate,
  input  logic [POS_W-1:0] delay,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_mask,
  output logic [POS_W-1:0] nxt_pos,
  output logic             ph,
  output logic             locked,
  output logic             realign,
  output logic             slot_go,
  output logic             resync
);
  logic [POS_W-1:0] load_val, adv_pos;
  logic fs_prev, fs_act, fs_det, adv_ph, nxt_ph, match;

  always_comb begin
    pos_mask = POS_W'(tdm_pkg::frame_bits(rate, BASE_BITS) - 1);
    fs_act   = fs_raw ^ fs_inv;
    fs_det   = fs_act & ~fs_prev;
    load_val = (~delay + 1'b1) & pos_mask;
    if (mode2x && !ph) begin
      adv_ph  = 1'b1;
      adv_pos = pos;
    end else begin
      adv_ph  = 1'b0;
      adv_pos = (pos + 1'b1) & pos_mask;
    end
    match   = locked && (adv_pos == load_val) && !adv_ph;
    realign = fs_det && !match;
    nxt_pos = fs_det ? load_val : adv_pos;
    nxt_ph  = fs_det ? 1'b0 : adv_ph;
    slot_go = (fs_det || locked) && !nxt_ph && (nxt_pos[BIDX_W-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      ph      <= 1'b0;
      locked  <= 1'b0;
      fs_prev <= 1'b1;
      resync  <= 1'b0;
    end else begin
      fs_prev <= fs_act;
      resync  <= fs_det && locked && !match;
      if (fs_det) locked <= 1'b1;
      if (locked || fs_det) begin
        pos <= nxt_pos;
        ph  <= nxt_ph;
      end
    end
  end

  // R1
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !mode2x && !fs_det) |=> pos == (($past(pos) + 1'b1) & $past(pos_mask)));
  // R3
  half_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && mode2x && !fs_det) |=> ph != $past(ph));
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
  parameter int POS_W  = 12,
  parameter int BIDX_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_in,
  input  logic                    rx_fall,
  input  logic                    locked,
  input  logic                    ph,
  input  logic                    realign,
  input  logic [POS_W-1:0]        pos,
  output logic                    rx_valid,
  output logic [BYTE_W-1:0]       rx_byte,
  output logic [POS_W-BIDX_W-1:0] rx_slot
);
  logic rx_neg, bit_in, samp, primed;
  logic [BYTE_W-1:0] sh;
  logic [BIDX_W-1:0] bidx;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_neg <= 1'b0;
    else        rx_neg <= rx_in;
  end

  always_comb begin
    bit_in = rx_fall ? rx_neg : rx_in;
    samp   = locked && !ph;
    bidx   = pos[BIDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      primed   <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_slot  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (realign) begin
        primed <= 1'b0;
      end else if (samp) begin
        sh <= {sh[BYTE_W-2:0], bit_in};
        if (bidx == '0) primed <= 1'b1;
        if (bidx == '1 && primed) begin
          rx_valid <= 1'b1;
          rx_byte  <= {sh[BYTE_W-2:0], bit_in};
          rx_slot  <= pos[POS_W-1:BIDX_W];
        end
      end
    end
  end

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R9
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !rx_valid);
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int POS_W     = 12,
  parameter int BIDX_W    = 3,
  parameter int BYTE_W    = 8,
  parameter int MAX_SLOTS = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    locked,
  input  logic                    ph,
  input  logic                    slot_go,
  input  logic [POS_W-1:0]        pos,
  input  logic [POS_W-1:0]        nxt_pos,
  input  logic [POS_W-1:0]        pos_mask,
  input  logic [MAX_SLOTS-1:0]    tx_mask,
  input  logic                    tx_push,
  input  logic [BYTE_W-1:0]       tx_byte,
  output logic                    tx_ready,
  output logic                    tx_req,
  output logic [POS_W-BIDX_W-1:0] tx_req_slot,
  output logic                    tx_dat,
  output logic                    tx_en
);
  localparam int SLOT_W = POS_W - BIDX_W;
  logic [BYTE_W-1:0] hold, cur;
  logic              hold_full;
  logic [SLOT_W-1:0] slot_mask, slot_now;
  logic [BIDX_W-1:0] bsel;

  always_comb begin
    slot_mask = pos_mask[POS_W-1:BIDX_W];
    slot_now  = pos[POS_W-1:BIDX_W];
    bsel      = BIDX_W'(BYTE_W - 1) - pos[BIDX_W-1:0];
    tx_ready  = !hold_full && !slot_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold        <= '0;
      hold_full   <= 1'b0;
      cur         <= '1;
      tx_req      <= 1'b0;
      tx_req_slot <= '0;
    end else begin
      tx_req <= 1'b0;
      if (slot_go) begin
        cur         <= hold_full ? hold : '1;
        hold_full   <= 1'b0;
        tx_req      <= 1'b1;
        tx_req_slot <= (nxt_pos[POS_W-1:BIDX_W] + 1'b1) & slot_mask;
      end else if (tx_push && !hold_full) begin
        hold      <= tx_byte;
        hold_full <= 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      tx_dat <= 1'b0;
    end else if (!ph) begin
      tx_en  <= locked && tx_mask[slot_now];
      tx_dat <= cur[bsel];
    end
  end

  // R9
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!tx_en && !tx_req));
  // R7
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int BASE_SLOTS = 128,
  parameter int MAX_SLOTS  = 512,
  parameter int BYTE_W     = 8,
  localparam int POS_W     = $clog2(MAX_SLOTS * BYTE_W),
  localparam int BIDX_W    = $clog2(BYTE_W),
  localparam int SLOT_W    = POS_W - BIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rate,
  input  logic               mode2x,
  input  logic               fs_inv,
  input  logic               rx_fall,
  input  logic [POS_W-1:0]   delay,
  input  logic               fsync,
  input  logic               rx_in,
  output logic               rx_valid,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic [SLOT_W-1:0]  rx_slot,
  input  logic [MAX_SLOTS-1:0] tx_mask,
  output logic               tx_req,
  output logic [SLOT_W-1:0]  tx_req_slot,
  input  logic               tx_push,
  input  logic [BYTE_W-1:0]  tx_byte,
  output logic               tx_ready,
  output logic               tx_dat,
  output logic               tx_en,
  output logic               resync
);
  localparam int BASE_BITS = BASE_SLOTS * BYTE_W;

  logic [POS_W-1:0] pos, pos_mask, nxt_pos;
  logic ph, locked, realign, slot_go;

  tdm_frame_timer #(.POS_W(POS_W), .BIDX_W(BIDX_W), .BASE_BITS(BASE_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .fs_raw(fsync), .fs_inv(fs_inv), .mode2x(mode2x),
    .rate(rate), .delay(delay), .pos(pos), .pos_mask(pos_mask), .nxt_pos(nxt_pos),
    .ph(ph), .locked(locked), .realign(realign), .slot_go(slot_go), .resync(resync)
  );

  tdm_rx_lane #(.POS_W(POS_W), .BIDX_W(BIDX_W), .BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_fall(rx_fall), .locked(locked),
    .ph(ph), .realign(realign), .pos(pos), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_slot(rx_slot)
  );

  tdm_tx_lane #(.POS_W(POS_W), .BIDX_W(BIDX_W), .BYTE_W(BYTE_W), .MAX_SLOTS(MAX_SLOTS)) u_tx (
    .clk(clk), .rst_n(rst_n), .locked(locked), .ph(ph), .slot_go(slot_go), .pos(pos),
    .nxt_pos(nxt_pos), .pos_mask(pos_mask), .tx_mask(tx_mask), .tx_push(tx_push),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .tx_req(tx_req), .tx_req_slot(tx_req_slot),
    .tx_dat(tx_dat), .tx_en(tx_en)
  );

  // R8
  resync_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);
endmodule

// File: tb/test_tdm_serial_port.sv
module test_tdm_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rate = 2'd0;
  logic mode2x = 1'b0, fs_inv = 1'b0, rx_fall = 1'b0;
  logic [11:0] delay = '0;
  logic fsync = 1'b0, rx_in = 1'b0;
  logic rx_valid, tx_req, tx_ready, tx_dat, tx_en, resync;
  logic [7:0] rx_byte;
  logic [8:0] rx_slot, tx_req_slot;
  logic [511:0] tx_mask = '0;
  logic tx_push = 1'b0;
  logic [7:0] tx_byte = '0;

  always #4 clk = ~clk;

  tdm_serial_port i_tdm_serial_port (
    .clk(clk), .rst_n(rst_n), .rate(rate), .mode2x(mode2x), .fs_inv(fs_inv),
    .rx_fall(rx_fall), .delay(delay), .fsync(fsync), .rx_in(rx_in),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_slot(rx_slot), .tx_mask(tx_mask),
    .tx_req(tx_req), .tx_req_slot(tx_req_slot), .tx_push(tx_push), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .tx_dat(tx_dat), .tx_en(tx_en), .resync(resync)
  );

  int checks = 0, fails = 0;
  int cyc = 0, e0 = 0, next_sync = -1, skew_next = 0;
  bit have_sync = 0;
  int nbits = 1024, nslots = 128, m = 1, lpos = 0;
  int rx_expect = 0, rx_count = 0, resync_cnt = 0, resync_exp = 0;
  logic [7:0] rxpat [512];
  logic [7:0] txexp [512];
  bit txv [512];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int bits_for(input int r);
    return 1024 << ((r > 2) ? 2 : r);
  endfunction

  function automatic int first_full(input int l, input int s);
    return ((l + 7) / 8) % s;
  endfunction

  task automatic step();
    int p, sl;
    bit b;
    @(posedge clk);
    cyc++;
    if (cyc == next_sync) begin
      if (have_sync && ((cyc - e0) % (nbits * m)) != 0) begin
        resync_exp++;
        for (int i = 0; i < 512; i++) txv[i] = 0;
        rx_expect = first_full(lpos, nslots);
      end
      if (!have_sync) rx_expect = first_full(lpos, nslots);
      have_sync = 1;
      e0 = cyc;
      next_sync = e0 + nbits * m + skew_next;
      skew_next = 0;
    end
    #1;
    tx_push = 1'b0;
    p = have_sync ? (lpos + (cyc - e0) / m) % nbits : 0;
    sl = p / 8;
    b = rxpat[sl][7 - (p % 8)];
    rx_in = have_sync ? b : 1'($urandom);
    fsync = fs_inv ^ (cyc + 1 == next_sync);
    #4;
    if (rx_fall) rx_in = ~b;
    #1;
    if (!have_sync) begin
      chk(!tx_en && !tx_req && !rx_valid && !resync, "R9 idle before sync", int'(tx_en), 0);
    end else begin
      chk(tx_en == tx_mask[sl], "R6 tx_en follows slot mask", int'(tx_en), int'(tx_mask[sl]));
      if (tx_en && txv[sl])
        chk(tx_dat == txexp[sl][7 - (p % 8)], "R6/R7 tx bit", int'(tx_dat),
            int'(txexp[sl][7 - (p % 8)]));
      if (tx_req) begin
        chk(int'(tx_req_slot) == (sl + 1) % nslots, "R7 request slot", int'(tx_req_slot),
            (sl + 1) % nslots);
        chk(tx_ready, "R7 ready after request", int'(tx_ready), 1);
        if (($urandom % 4) != 0) begin
          tx_byte = 8'($urandom);
          tx_push = 1'b1;
          txexp[tx_req_slot] = tx_byte;
        end else begin
          txexp[tx_req_slot] = 8'hFF;
        end
        txv[tx_req_slot] = 1;
      end
      if (rx_valid) begin
        rx_count++;
        chk(int'(rx_slot) == rx_expect, "R5 rx slot order", int'(rx_slot), rx_expect);
        chk(rx_byte == rxpat[rx_slot], "R2/R3/R4 rx byte", int'(rx_byte), int'(rxpat[rx_slot]));
        rx_expect = (int'(rx_slot) + 1) % nslots;
      end
    end
    if (resync) resync_cnt++;
  endtask

  task automatic scenario(input int r, input bit x2, input int d, input bit inv,
                          input bit rf, input int skew, input int frames);
    rst_n = 1'b0;
    tx_push = 1'b0;
    rate = 2'(r); mode2x = x2; delay = 12'(d); fs_inv = inv; rx_fall = rf;
    fsync = inv;
    nbits = bits_for(r); nslots = nbits / 8; m = x2 ? 2 : 1;
    lpos = (nbits - (d % nbits)) % nbits;
    for (int i = 0; i < 512; i++) begin
      rxpat[i] = 8'($urandom);
      txv[i] = 0;
      tx_mask[i] = (($urandom % 4) != 0);
    end
    have_sync = 0; rx_count = 0; resync_cnt = 0; resync_exp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #5;
    chk(!rx_valid && !tx_en && !tx_req && !resync && tx_ready, "R9 reset state",
        int'(tx_en), 0);
    next_sync = cyc + 40;
    skew_next = skew;
    repeat (40 + frames * nbits * m + 50) step();
    chk(resync_cnt == resync_exp, "R8 resync count", resync_cnt, resync_exp);
    chk(rx_count >= nslots, "R5 rx byte count", rx_count, nslots);
  endtask

  initial begin
    void'($urandom(32'd4711));
    fork
      begin
        // R1 R2: 128 slots, delay wraps so slot 0 starts one bit before sync
        scenario(0, 0, 1023, 0, 0, 0, 3);
        // R3: two clocks per bit, inverted sync, delay of one bit
        scenario(1, 1, 1, 1, 0, 0, 2);
        // R4 R8: 512 slots, falling-edge capture, misaligned second sync
        scenario(2, 0, 13, 0, 1, 37, 3);
        // R1 R8: code 3 behaves as 512, two clocks per bit, early sync
        scenario(3, 1, 0, 0, 1, -5, 2);
        // R5: partial first slot suppressed, 256 slots
        scenario(1, 0, 5, 1, 0, 0, 2);
      end
      begin
        #(8 * 190000);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule